// File: doc/BRIEF.md
# Streaming Chunk ECC Engine for NAND Pages

This block produces a 22-bit Hamming-style check code over every 256-byte chunk of a NAND page. Bytes arrive one per clock with a valid strobe. The code is built from two kinds of parity. The first kind covers the byte offset within the chunk: for each offset bit there is a pair of parity bits. The second kind covers the bit position within a byte, again as pairs. The block needs no memory: the running parity holds everything, and a result appears one clock after the last byte of a chunk.

A write to flash uses the generated code, which is packed into three bytes. On a read the caller presents the code that was stored with the chunk. The block forms the syndrome and classifies the chunk in one of four ways: clean, a single flipped data bit (with its byte offset and bit position), a single flipped code bit, or damage that cannot be repaired. The caller applies any repair to its own buffer. A 512-byte page gives two results and a 2048-byte page gives eight. Each result carries the index of its chunk within the page.

Top module: `ecc_chunk_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `res_valid` is low. After reset, byte counting starts at offset 0 and the first result carries chunk index 0.
- R2: `res_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the 256th byte of a chunk. Cycles with `in_valid` low do not advance the count and do not change the code.
- R3: `res_code` packs the parity as follows. Bits [1:0] are always 1. For bit position j = 0..2, bit 2+2j is the even parity of all data bits whose position has bit j = 0, and bit 3+2j covers those whose position has bit j = 1. For offset bit k = 0..7, bit 8+2k is the even parity of all bytes whose offset has bit k = 0, and bit 9+2k covers those whose offset has bit k = 1.
- R4: In check mode (`chk_mode` high with the last byte), the syndrome is `ref_code` XOR the computed code over bits [23:2]. A zero syndrome gives status 0 (clean).
- R5: If both bits of every one of the 11 pairs in the syndrome differ, the status is 1 (single data bit). `res_err_byte` is then the syndrome's odd-side offset bits (bit k from bit 9+2k), and `res_err_bit` is its odd-side position bits (bit j from bit 3+2j).
- R6: A syndrome with exactly one bit set gives status 2 (code bit hit), and the data is considered intact.
- R7: Any other nonzero syndrome gives status 3 (uncorrectable). This covers every two-bit data error in a chunk.
- R8: `res_err_byte` and `res_err_bit` are zero whenever the status is not 1.
- R9: In write mode (`chk_mode` low with the last byte), the status is 0 and `res_code` still carries the computed code.
- R10: `res_chunk` counts 0 to PAGE_BYTES/256-1 over successive chunks, then returns to 0. The default of 2048 gives eight chunks.
- R11: Bits [1:0] of `ref_code` have no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data byte strobe |
| in_data | input | 8 | Data byte |
| chk_mode | input | 1 | Check mode, sampled with the last byte of a chunk |
| ref_code | input | 24 | Stored code, sampled with the last byte of a chunk |
| res_valid | output | 1 | Result strobe, one cycle per chunk |
| res_code | output | 24 | Computed code of the chunk |
| res_status | output | 2 | 0 clean, 1 data bit, 2 code bit, 3 uncorrectable |
| res_chunk | output | 3 | Chunk index within the page |
| res_err_byte | output | 8 | Offset of the flipped byte |
| res_err_bit | output | 3 | Position of the flipped bit |

## Verification
The assertions check on every cycle that:
- the result strobe lasts a single cycle;
- the pad bits of the code stay at one;
- the location fields are zero unless a data bit is reported;
- a chunk ended in write mode always reports clean;
- idle cycles leave the byte count untouched.

Only the bench's scenarios can show the rest:
- the parity values themselves;
- the correct classification of clean, single-data, single-code and double-bit damage;
- the exact reported location, including the corner positions at offset 0 bit 0 and offset 255 bit 7;
- the wrap of the chunk index.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int CHUNK_BYTES = 256;
  localparam int BYTE_W      = 8;
  localparam int OFS_W       = $clog2(CHUNK_BYTES);
  localparam int POS_W       = $clog2(BYTE_W);
  localparam int LINE_W      = 2 * OFS_W;
  localparam int COL_W       = 2 * POS_W;
  localparam int PAD_W       = 2;
  localparam int CODE_W      = LINE_W + COL_W + PAD_W;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXABLE  = 2'd1,
    ECC_CODE_HIT = 2'd2,
    ECC_FATAL    = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              last_byte,
  output logic [LINE_W-1:0] line_next,
  output logic [COL_W-1:0]  col_next
);
  logic [OFS_W-1:0]  ofs_q;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;
  logic [BYTE_W-1:0] dat;
  logic              byte_par;

  function automatic logic [BYTE_W-1:0] pos_mask(input int j);
    logic [BYTE_W-1:0] m;
    for (int t = 0; t < BYTE_W; t++) m[t] = ((t >> j) & 1) == 1;
    return m;
  endfunction

  assign dat       = in_valid ? in_data : '0;
  assign byte_par  = ^dat;
  assign last_byte = in_valid && (ofs_q == OFS_W'(CHUNK_BYTES - 1));

  always_comb begin
    line_next = line_q;
    for (int k = 0; k < OFS_W; k++)
      line_next[2*k + int'(ofs_q[k])] = line_q[2*k + int'(ofs_q[k])] ^ byte_par;
  end

  genvar gj;
  generate
    for (gj = 0; gj < POS_W; gj++) begin : g_col
      assign col_next[2*gj+1] = col_q[2*gj+1] ^ (^(dat & pos_mask(gj)));
      assign col_next[2*gj]   = col_q[2*gj]   ^ (^(dat & ~pos_mask(gj)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      line_q <= '0;
      col_q  <= '0;
    end else if (in_valid) begin
      ofs_q  <= ofs_q + 1'b1;
      line_q <= last_byte ? '0 : line_next;
      col_q  <= last_byte ? '0 : col_next;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ofs_q));
  assert_chunk_clear_R2: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> (line_q == '0) && (col_q == '0) && (ofs_q == '0));
endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
  import ecc_pkg::*;
(
  input  logic [LINE_W-1:0] syn_line,
  input  logic [COL_W-1:0]  syn_col,
  output ecc_status_e       status,
  output logic [OFS_W-1:0]  err_ofs,
  output logic [POS_W-1:0]  err_pos
);
  logic [OFS_W-1:0] line_split;
  logic [POS_W-1:0] col_split;
  logic [OFS_W-1:0] odd_line;
  logic [POS_W-1:0] odd_col;
  logic             any_set;
  logic             all_split;
  int               ones;

  genvar gk, gj;
  generate
    for (gk = 0; gk < OFS_W; gk++) begin : g_line
      assign line_split[gk] = syn_line[2*gk] ^ syn_line[2*gk+1];
      assign odd_line[gk]   = syn_line[2*gk+1];
    end
    for (gj = 0; gj < POS_W; gj++) begin : g_col
      assign col_split[gj] = syn_col[2*gj] ^ syn_col[2*gj+1];
      assign odd_col[gj]   = syn_col[2*gj+1];
    end
  endgenerate

  assign any_set   = |{syn_line, syn_col};
  assign all_split = &{line_split, col_split};
  assign ones      = $countones({syn_line, syn_col});

  always_comb begin
    status  = ECC_CLEAN;
    err_ofs = '0;
    err_pos = '0;
    if (!any_set) begin
      status = ECC_CLEAN;
    end else if (all_split) begin
      status  = ECC_FIXABLE;
      err_ofs = odd_line;
      err_pos = odd_col;
    end else if (ones == 1) begin
      status = ECC_CODE_HIT;
    end else begin
      status = ECC_FATAL;
    end
  end
endmodule

// File: rtl/ecc_chunk_engine.sv
module ecc_chunk_engine
  import ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  localparam int CHUNKS    = PAGE_BYTES / CHUNK_BYTES,
  localparam int CIDX_W    = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              chk_mode,
  input  logic [23:0]       ref_code,
  output logic              res_valid,
  output logic [23:0]       res_code,
  output logic [1:0]        res_status,
  output logic [CIDX_W-1:0] res_chunk,
  output logic [7:0]        res_err_byte,
  output logic [2:0]        res_err_bit
);
  logic              last_byte;
  logic [LINE_W-1:0] line_next;
  logic [COL_W-1:0]  col_next;
  logic [CODE_W-1:0] comp_code;
  ecc_status_e       dec_status;
  logic [OFS_W-1:0]  dec_ofs;
  logic [POS_W-1:0]  dec_pos;
  logic [CIDX_W-1:0] cidx_q;

  ecc_parity_acc u_acc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .last_byte (last_byte),
    .line_next (line_next),
    .col_next  (col_next)
  );

  assign comp_code = {line_next, col_next, {PAD_W{1'b1}}};

  ecc_syndrome_decode u_dec (
    .syn_line (ref_code[CODE_W-1 -: LINE_W] ^ line_next),
    .syn_col  (ref_code[PAD_W +: COL_W] ^ col_next),
    .status   (dec_status),
    .err_ofs  (dec_ofs),
    .err_pos  (dec_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_code     <= '0;
      res_status   <= ECC_CLEAN;
      res_chunk    <= '0;
      res_err_byte <= '0;
      res_err_bit  <= '0;
      cidx_q       <= '0;
    end else begin
      res_valid <= last_byte;
      if (last_byte) begin
        res_code     <= comp_code;
        res_chunk    <= cidx_q;
        res_status   <= chk_mode ? dec_status : ECC_CLEAN;
        res_err_byte <= chk_mode ? dec_ofs : '0;
        res_err_bit  <= chk_mode ? dec_pos : '0;
        cidx_q       <= (cidx_q == CIDX_W'(CHUNKS - 1)) ? '0 : cidx_q + 1'b1;
      end
    end
  end

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_pad_ones_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_code[1:0] == 2'b11);
  assert_loc_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status != ECC_FIXABLE) |-> (res_err_byte == '0 && res_err_bit == '0));
  assert_write_clean_R9: assert property (@(posedge clk) disable iff (rst)
    (last_byte && !chk_mode) |=> (res_valid && res_status == ECC_CLEAN));
endmodule

// File: tb/ecc_chunk_engine_tb.sv
module ecc_chunk_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        chk_mode = 1'b0;
  logic [23:0] ref_code = '0;
  logic        res_valid;
  logic [23:0] res_code;
  logic [1:0]  res_status;
  logic [2:0]  res_chunk;
  logic [7:0]  res_err_byte;
  logic [2:0]  res_err_bit;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [2:0] exp_chunk = '0;
  logic [7:0] gold [256];
  logic [7:0] sbuf [256];

  always #2.5 clk = ~clk;

  ecc_chunk_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .chk_mode(chk_mode), .ref_code(ref_code), .res_valid(res_valid),
    .res_code(res_code), .res_status(res_status), .res_chunk(res_chunk),
    .res_err_byte(res_err_byte), .res_err_bit(res_err_bit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_code();
    logic [23:0] c = 24'h3;
    for (int i = 0; i < 256; i++)
      for (int t = 0; t < 8; t++)
        if (gold[i][t]) begin
          for (int k = 0; k < 8; k++) c[8 + 2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) c[2 + 2*j + ((t >> j) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic send_chunk(input logic chk, input logic [23:0] rc);
    for (int i = 0; i < 256; i++) begin
      while (($urandom % 4) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hA5;
        if (res_valid) check("R2 early strobe", 1, 0);
      end
      @(negedge clk);
      if (i > 0 && res_valid) check("R2 early strobe", 1, 0);
      in_valid = 1'b1;
      in_data  = sbuf[i];
      chk_mode = chk;
      ref_code = rc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk_mode = ~chk;
    ref_code = ~rc;
  endtask

  task automatic expect_result(input logic [23:0] code, input logic [1:0] st,
                               input logic [7:0] eb, input logic [2:0] et, input string req);
    check("R2 strobe", res_valid, 1);
    check({"R3 code ", req}, res_code, code);
    check({req, " status"}, res_status, st);
    check({req, " R8 location"}, {res_err_byte, res_err_bit}, {eb, et});
    check("R10 chunk index", res_chunk, exp_chunk);
    exp_chunk = exp_chunk + 1'b1;
    @(negedge clk);
    check("R2 single cycle", res_valid, 0);
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < 256; i++)
      gold[i] = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : 8'($urandom);
    for (int i = 0; i < 256; i++) sbuf[i] = gold[i];
  endtask

  task automatic run_scenario(input int sc, input int kind);
    logic [23:0] c;
    int p1, p2;
    fill(kind);
    c = model_code();
    case (sc)
      0: begin send_chunk(1'b0, ~c); expect_result(c, 2'd0, 0, 0, "R9 write"); end
      1: begin send_chunk(1'b1, c); expect_result(c, 2'd0, 0, 0, "R4 clean"); end
      2: begin
        p1 = $urandom % 2048;
        sbuf[p1/8][p1%8] ^= 1'b1;
        gold[p1/8][p1%8] ^= 1'b1;
        send_chunk(1'b1, c);
        expect_result(model_code(), 2'd1, 8'(p1/8), 3'(p1%8), "R5 single data");
      end
      3: begin
        p1 = 2 + ($urandom % 22);
        send_chunk(1'b1, c ^ (24'h1 << p1));
        expect_result(c, 2'd2, 0, 0, "R6 code bit");
      end
      4: begin
        p1 = $urandom % 2048;
        p2 = (p1 + 1 + ($urandom % 2047)) % 2048;
        sbuf[p1/8][p1%8] ^= 1'b1;
        sbuf[p2/8][p2%8] ^= 1'b1;
        gold[p1/8][p1%8] ^= 1'b1;
        gold[p2/8][p2%8] ^= 1'b1;
        send_chunk(1'b1, c);
        expect_result(model_code(), 2'd3, 0, 0, "R7 double data");
      end
      default: begin
        send_chunk(1'b1, c ^ 24'h3);
        expect_result(c, 2'd0, 0, 0, "R11 pad ignored");
      end
    endcase
  endtask

  task automatic corner_flip(input int b, input int t);
    logic [23:0] c;
    fill(0);
    c = model_code();
    sbuf[b][t] ^= 1'b1;
    gold[b][t] ^= 1'b1;
    send_chunk(1'b1, c);
    expect_result(model_code(), 2'd1, 8'(b), 3'(t), "R5 corner");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1 reset strobe", res_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", res_valid, 0);
    fill(1); send_chunk(1'b0, 24'h0);
    expect_result(24'hFFFF_FF & 24'h000003, 2'd0, 0, 0, "R3 zeros");
    fill(2); send_chunk(1'b0, 24'h0);
    expect_result(24'h000003, 2'd0, 0, 0, "R3 ones even count");
    for (int r = 0; r < 3; r++)
      for (int sc = 0; sc < 6; sc++) run_scenario(sc, 0);
    corner_flip(0, 0);
    corner_flip(255, 7);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule